// File: doc/BRIEF.md
# Dual-Clock Elastic Byte Buffer with Start Threshold

This block moves data words from a write clock domain into an unrelated read clock domain. A typical use has a bursty source, such as a bridge that strobes bytes at 60 MHz, feeding a consumer that runs at 50 MHz. Both sides keep binary and Gray-coded pointers. Each Gray pointer reaches the other domain through a flip-flop chain whose length is a parameter. Full and empty are computed from the synchronized copies, so they are pessimistic: each flag clears only some cycles after the far side has acted.

On the read side, a start gate withholds data until the stored level reaches a threshold set by the consumer. The buffer can therefore fill before streaming begins and absorb rate differences. When the buffer drains to zero, the gate closes again and waits for the threshold once more. A parameter selects the read style. In registered mode, data follows the request by one read clock. In look-ahead mode, the head word is already on the output while data is offered. Requests that the flags or the gate refuse change nothing, and each refused request sets a sticky error flag in its own domain.

Top module: `afifo_prefill`

## Requirements
- R1: After reset, rd_empty_o is 1, wr_full_o is 0, rd_ready_o is 0, rd_valid_o is 0, and both sticky error flags are 0.
- R2: Words leave in the order they were accepted, with no loss and no duplication. Each Gray pointer changes by at most one bit per clock.
- R3: wr_full_o is 1 once DEPTH words are held. A write while full stores nothing, leaves the read-out sequence unchanged, and sets wr_overflow_o, which stays 1 until the write reset.
- R4: A read while rd_ready_o is 0 removes nothing and produces no rd_valid_o. It sets rd_underflow_o, which stays 1 until the read reset.
- R5: rd_ready_o stays 0 until the read-side level reaches the effective threshold. The effective threshold is rd_start_level_i, raised to 1 if it is 0 and limited to DEPTH.
- R6: Once the read side observes an empty buffer after streaming, the gate re-arms. rd_ready_o then stays 0 until the threshold is reached again.
- R7: With SHOW_AHEAD=0, a read accepted at a read clock edge gives rd_valid_o=1 and the word on rd_data_o during the following read clock cycle.
- R8: With SHOW_AHEAD=1, while rd_ready_o is 1, rd_data_o already holds the oldest stored word, and rd_valid_o equals rd_ready_o.
- R9: After a write into an empty buffer, rd_empty_o is still 1 one read edge later and is 0 within SYNC_STAGES+2 read clocks. After a read from a full buffer, wr_full_o is still 1 just after that read edge and is 0 within SYNC_STAGES+2 write clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write domain clock |
| wr_rst_ni | input | 1 | Write domain asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Write data |
| wr_full_o | output | 1 | Buffer full (pessimistic) |
| wr_overflow_o | output | 1 | Sticky: write attempted while full |
| rd_clk_i | input | 1 | Read domain clock |
| rd_rst_ni | input | 1 | Read domain asynchronous reset, active low |
| rd_en_i | input | 1 | Read request |
| rd_start_level_i | input | $clog2(DEPTH)+1 | Level at which streaming starts |
| rd_data_o | output | DATA_W | Read data |
| rd_valid_o | output | 1 | rd_data_o carries a word |
| rd_ready_o | output | 1 | A read request would be accepted |
| rd_empty_o | output | 1 | Buffer empty (pessimistic) |
| rd_underflow_o | output | 1 | Sticky: read attempted while not ready |

## Verification
Each kind of pointer corruption shows up at the ports in its own way.

- A pointer that advances on a refused request appears as a skipped or repeated word in the next read-out.
- A wrong full comparison appears as wr_full_o missing on the DEPTH-th write, or as an overwritten word surfacing DEPTH reads later.
- A gate that never re-arms, or opens early, appears at once as rd_ready_o being 1 while fewer words than the threshold are held.
- Synchronizer paths that are too short or skipped appear as flags clearing on the very next edge, instead of after the stage latency.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  typedef enum logic {
    GATE_WAIT   = 1'b0,
    GATE_STREAM = 1'b1
  } gate_e;
endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/afifo_wr_ctl.sv
module afifo_wr_ctl #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW:0]   rd_gray_sync_i,
  output logic          full_o,
  output logic          fire_o,
  output logic [AW-1:0] addr_o,
  output logic [AW:0]   gray_o,
  output logic          overflow_o
);
  logic [AW:0] bin_q, bin_d, gray_q;
  logic        ovf_q;

  assign full_o = (gray_q == {~rd_gray_sync_i[AW:AW-1], rd_gray_sync_i[AW-2:0]});
  assign fire_o = wr_en_i && !full_o;
  assign bin_d  = bin_q + {{AW{1'b0}}, fire_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= bin_d ^ (bin_d >> 1);
      if (wr_en_i && full_o) ovf_q <= 1'b1;
    end
  end

  assign addr_o     = bin_q[AW-1:0];
  assign gray_o     = gray_q;
  assign overflow_o = ovf_q;

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full_o) |=> $stable(gray_q));
  assert_overflow_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  assert_wr_gray_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/afifo_rd_ctl.sv
module afifo_rd_ctl
  import afifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW:0]   start_level_i,
  input  logic [AW:0]   wr_gray_sync_i,
  output logic          empty_o,
  output logic          ready_o,
  output logic          fire_o,
  output logic [AW-1:0] addr_o,
  output logic [AW:0]   gray_o,
  output logic          underflow_o
);
  localparam logic [AW:0] DEPTH_L = (AW+1)'(1 << AW);

  logic [AW:0] bin_q, bin_d, gray_q, wbin, level, thr;
  gate_e       gate_q;
  logic        unf_q;

  always_comb begin
    wbin[AW] = wr_gray_sync_i[AW];
    for (int i = AW-1; i >= 0; i--) wbin[i] = wbin[i+1] ^ wr_gray_sync_i[i];
  end

  always_comb begin
    if (start_level_i == '0)         thr = (AW+1)'(1);
    else if (start_level_i > DEPTH_L) thr = DEPTH_L;
    else                             thr = start_level_i;
  end

  assign level   = wbin - bin_q;
  assign empty_o = (gray_q == wr_gray_sync_i);
  assign ready_o = (gate_q == GATE_STREAM) && !empty_o;
  assign fire_o  = rd_en_i && ready_o;
  assign bin_d   = bin_q + {{AW{1'b0}}, fire_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
      gate_q <= GATE_WAIT;
      unf_q  <= 1'b0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= bin_d ^ (bin_d >> 1);
      if (rd_en_i && !ready_o) unf_q <= 1'b1;
      case (gate_q)
        GATE_WAIT:   if (level >= thr) gate_q <= GATE_STREAM;
        GATE_STREAM: if (empty_o)      gate_q <= GATE_WAIT;
        default:     gate_q <= GATE_WAIT;
      endcase
    end
  end

  assign addr_o      = bin_q[AW-1:0];
  assign gray_o      = gray_q;
  assign underflow_o = unf_q;

  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !ready_o) |=> $stable(gray_q));
  assert_underflow_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_q |=> unf_q);
  assert_gate_threshold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_q == GATE_STREAM) |-> $past(level >= thr));
  assert_gate_rearm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_q == GATE_STREAM && empty_o) |=> !ready_o);
  assert_rd_gray_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/afifo_prefill.sv
module afifo_prefill #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit SHOW_AHEAD  = 1'b0,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic              wr_clk_i,
  input  logic              wr_rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_full_o,
  output logic              wr_overflow_o,
  input  logic              rd_clk_i,
  input  logic              rd_rst_ni,
  input  logic              rd_en_i,
  input  logic [AW:0]       rd_start_level_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              rd_ready_o,
  output logic              rd_empty_o,
  output logic              rd_underflow_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_fire, rd_fire;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [AW:0]       wr_gray, rd_gray, wr_gray_rs, rd_gray_ws;

  afifo_wr_ctl #(.AW(AW)) u_wr (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .wr_en_i(wr_en_i),
    .rd_gray_sync_i(rd_gray_ws), .full_o(wr_full_o), .fire_o(wr_fire),
    .addr_o(wr_addr), .gray_o(wr_gray), .overflow_o(wr_overflow_o)
  );

  afifo_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .d_i(rd_gray), .q_o(rd_gray_ws)
  );

  afifo_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .d_i(wr_gray), .q_o(wr_gray_rs)
  );

  afifo_rd_ctl #(.AW(AW)) u_rd (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .rd_en_i(rd_en_i),
    .start_level_i(rd_start_level_i), .wr_gray_sync_i(wr_gray_rs),
    .empty_o(rd_empty_o), .ready_o(rd_ready_o), .fire_o(rd_fire),
    .addr_o(rd_addr), .gray_o(rd_gray), .underflow_o(rd_underflow_o)
  );

  always_ff @(posedge wr_clk_i) begin
    if (wr_fire) mem[wr_addr] <= wr_data_i;
  end

  if (SHOW_AHEAD) begin : g_ahead
    assign rd_data_o  = mem[rd_addr];
    assign rd_valid_o = rd_ready_o;
  end else begin : g_reg
    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    always_ff @(posedge rd_clk_i or negedge rd_rst_ni) begin
      if (!rd_rst_ni) begin
        data_q  <= '0;
        valid_q <= 1'b0;
      end else begin
        valid_q <= rd_fire;
        if (rd_fire) data_q <= mem[rd_addr];
      end
    end
    assign rd_data_o  = data_q;
    assign rd_valid_o = valid_q;

    assert_valid_follows_R7: assert property (@(posedge rd_clk_i) disable iff (!rd_rst_ni)
      rd_valid_o |-> $past(rd_en_i && rd_ready_o));
  end
endmodule

// File: tb/tb_afifo_prefill.sv
`timescale 1ns/100ps
module tb_afifo_prefill;
  localparam int DW = 8, DEPTH = 16, ST = 2, AW = $clog2(DEPTH);

  logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [AW:0] start_lvl = 5'd4;

  logic [DW-1:0] d_data, s_data;
  logic d_full, d_ovf, d_valid, d_ready, d_empty, d_unf;
  logic s_full, s_ovf, s_valid, s_ready, s_empty, s_unf;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4.0 wr_clk = ~wr_clk;
  always #5.3 rd_clk = ~rd_clk;

  afifo_prefill #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(ST), .SHOW_AHEAD(1'b0)) dut (
    .wr_clk_i(wr_clk), .wr_rst_ni(wr_rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_full_o(d_full), .wr_overflow_o(d_ovf), .rd_clk_i(rd_clk), .rd_rst_ni(rd_rst_n),
    .rd_en_i(rd_en), .rd_start_level_i(start_lvl), .rd_data_o(d_data), .rd_valid_o(d_valid),
    .rd_ready_o(d_ready), .rd_empty_o(d_empty), .rd_underflow_o(d_unf)
  );

  afifo_prefill #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(ST), .SHOW_AHEAD(1'b1)) dut_sa (
    .wr_clk_i(wr_clk), .wr_rst_ni(wr_rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_full_o(s_full), .wr_overflow_o(s_ovf), .rd_clk_i(rd_clk), .rd_rst_ni(rd_rst_n),
    .rd_en_i(rd_en), .rd_start_level_i(start_lvl), .rd_data_o(s_data), .rd_valid_o(s_valid),
    .rd_ready_o(s_ready), .rd_empty_o(s_empty), .rd_underflow_o(s_unf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_rd(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic wait_wr(input int n);
    repeat (n) @(negedge wr_clk);
  endtask

  task automatic write_word(input logic [DW-1:0] v);
    @(negedge wr_clk);
    wr_en = 1; wr_data = v;
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic read_one(input logic [DW-1:0] exp, input string tag);
    @(negedge rd_clk);
    chk({tag, " R8 ahead ready"}, s_ready, 1);
    chk({tag, " R8 ahead head"}, s_data, exp);
    chk({tag, " R8 ahead valid"}, s_valid, 1);
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    chk({tag, " R7 valid"}, d_valid, 1);
    chk({tag, " R2 order"}, d_data, exp);
  endtask

  task automatic t_reset;
    chk("R1 empty", d_empty, 1);
    chk("R1 full", d_full, 0);
    chk("R1 ready", d_ready, 0);
    chk("R1 valid", d_valid, 0);
    chk("R1 overflow", d_ovf, 0);
    chk("R1 underflow", d_unf, 0);
  endtask

  task automatic t_latency;
    write_word(8'hA0);
    @(negedge rd_clk);
    chk("R9 empty held", d_empty, 1);
    wait_rd(ST + 2);
    chk("R9 empty cleared", d_empty, 0);
    chk("R5 below threshold", d_ready, 0);
  endtask

  task automatic t_underflow;
    @(negedge rd_clk);
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    chk("R4 underflow set", d_unf, 1);
    chk("R4 no valid", d_valid, 0);
    wait_rd(3);
    chk("R4 underflow sticky", s_unf, 1);
  endtask

  task automatic t_prefill;
    write_word(8'hA1);
    write_word(8'hA2);
    wait_rd(5);
    chk("R5 level 3 gated", d_ready, 0);
    write_word(8'hA3);
    wait_rd(5);
    chk("R5 threshold open", d_ready, 1);
    for (int i = 0; i < 4; i++) read_one(8'hA0 + DW'(i), "prefill");
    wait_rd(2);
    chk("R6 drained ready", d_ready, 0);
    chk("R6 drained empty", d_empty, 1);
  endtask

  task automatic t_rearm;
    write_word(8'hB0);
    write_word(8'hB1);
    wait_rd(5);
    chk("R6 rearmed gate", d_ready, 0);
    chk("R6 data present", d_empty, 0);
    write_word(8'hB2);
    write_word(8'hB3);
    wait_rd(5);
    chk("R6 reopened", d_ready, 1);
    for (int i = 0; i < 4; i++) read_one(8'hB0 + DW'(i), "rearm");
  endtask

  task automatic t_full;
    wait_rd(5);
    wait_wr(5);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 not yet full", d_full, 0);
      write_word(8'hC0 + DW'(i));
    end
    chk("R3 full", d_full, 1);
    write_word(8'hEE);
    chk("R3 overflow set", d_ovf, 1);
    chk("R3 still full", d_full, 1);
    wait_rd(5);
    @(negedge rd_clk);
    chk("R8 head at full", s_data, 8'hC0);
    rd_en = 1;
    @(posedge rd_clk);
    #1;
    chk("R9 full held", d_full, 1);
    @(negedge rd_clk);
    rd_en = 0;
    chk("R7 valid at full", d_valid, 1);
    chk("R2 first word", d_data, 8'hC0);
    wait_wr(ST + 2);
    chk("R9 full cleared", d_full, 0);
    for (int i = 1; i < DEPTH; i++) read_one(8'hC0 + DW'(i), "full");
    wait_rd(5);
    chk("R3 dropped word absent", d_empty, 1);
    chk("R3 dropped word not offered", d_ready, 0);
    chk("R3 overflow sticky", d_ovf, 1);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge wr_clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    wait_wr(3);
    wait_rd(3);
    @(negedge wr_clk) wr_rst_n = 1;
    @(negedge rd_clk) rd_rst_n = 1;
    wait_rd(2);
    t_reset();
    t_latency();
    t_underflow();
    t_prefill();
    t_rearm();
    t_full();
    done = 1;
    summary();
    $finish;
  end
endmodule